// File: doc/BRIEF.md
# Soft-Shutdown Gate Sequencer

This block decides, for each channel of a multi-phase step-down controller, how the power stage behaves when that channel is switched off and when it is switched back on. A channel counts as active only when three things hold: its enable input is high, its undervoltage fault latch is clear, and the shared input-undervoltage flag is clear. When a channel stops being active, the block turns off its PWM and holds its low-side gate off. It also closes a discharge switch so that the output bleeds down gently to ground.

An analog comparator reports when the output has fallen below about 0.3 V. That flag is resynchronised through two flops. Once the synchronised flag is seen, the channel clamps: it opens the discharge switch and latches the low-side gate on, which ties the output and the switch node to ground. When the channel becomes active again from the clamp, it asserts a soft-start request for a fixed number of cycles before it returns to normal running. When the channel becomes active again while it is still discharging, the discharge is abandoned and the channel goes straight back to running. A single reference-enable output stays high until every channel is clamped, so the threshold comparators keep an accurate reference for the whole discharge.

Top module: `ssd_sequencer`

## Requirements
- R1: In the first cycle after a synchronous reset, every channel is in the discharge state (discharge switch 1, PWM enable 0, soft-start 0, low-side command 01), and the reference enable is 1.
- R2: A running channel enters discharge on the next clock edge if any one of these holds: its enable input is low, its UV fault latch is set, or the shared UVLO flag is set.
- R3: While a channel discharges, its discharge switch is 1, its PWM enable is 0 and its low-side command is 01 (held off).
- R4: The below-threshold flag passes through two synchronising flops. A flag set before clock edge k moves a discharging, still-disabled channel into clamp at edge k+2, and the channel is still discharging after edge k+1.
- R5: A clamped channel has low-side command 10 (held on), discharge switch 0 and PWM enable 0. It stays clamped while it is disabled, whatever the below-threshold flag does.
- R6: A channel that becomes active while discharging goes to run on the next edge (discharge switch 0, PWM enable 1, low-side command 00 meaning follow the PWM, soft-start 0). This holds even if the below-threshold flag is high in the same cycle.
- R7: A clamped channel that becomes active enters soft-start for exactly START_CYCLES cycles (soft-start 1, PWM enable 1, discharge switch 0, low-side command 00) and then runs with soft-start 0.
- R8: A channel that is disabled during soft-start goes to discharge on the next edge.
- R9: The reference enable is 0 only when every channel is clamped. A single channel that is not clamped keeps it at 1.
- R10: The channels sequence independently: the inputs of one channel never change the outputs of another, except through the shared UVLO flag and the reference enable.

Ports are per channel. Channel i uses bit i of each vector and bits [2i+1:2i] of `ls_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | NCH | Per-channel enable level |
| uv_latch | input | NCH | Per-channel undervoltage fault latch |
| uvlo | input | 1 | Shared input undervoltage lockout flag |
| below_raw | input | NCH | Asynchronous "output below 0.3 V" comparator flags |
| dsch_sw_en | output | NCH | Discharge switch enable |
| pwm_en | output | NCH | PWM controller enable |
| ss_active | output | NCH | Soft-start request to the PWM |
| ls_cmd | output | 2*NCH | Low-side gate command: 00 follow PWM, 01 held off, 10 held on |
| ref_en | output | 1 | Shared reference enable |

## Verification
The assertions assume two things about the inputs. The enable, fault-latch and UVLO inputs are already synchronous to the clock. Only the comparator flag can change asynchronously, and the two-flop stage absorbs it. The bench therefore changes every input only at the falling edge, which keeps it inside those assumptions, and it samples the outputs at the following falling edge. Each check is timed by counting the sync flops and the state register, so the clamp is expected two edges after the flag has been captured.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DISCH = 2'd1,
        ST_CLAMP = 2'd2,
        ST_START = 2'd3
    } chan_st_e;

    typedef enum logic [1:0] {
        LS_PWM = 2'b00,
        LS_OFF = 2'b01,
        LS_ON  = 2'b10
    } ls_cmd_e;

    typedef struct packed {
        logic    dsch;
        logic    pwm;
        logic    ss;
        ls_cmd_e ls;
    } chan_out_t;

    function automatic chan_out_t decode_state(chan_st_e st);
        chan_out_t o;
        o = '{dsch: 1'b0, pwm: 1'b0, ss: 1'b0, ls: LS_OFF};
        case (st)
            ST_RUN:   begin o.pwm = 1'b1; o.ls = LS_PWM; end
            ST_DISCH: begin o.dsch = 1'b1; o.ls = LS_OFF; end
            ST_CLAMP: begin o.ls = LS_ON; end
            ST_START: begin o.pwm = 1'b1; o.ss = 1'b1; o.ls = LS_PWM; end
            default:  o.ls = LS_OFF;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/ssd_sync2.sv
module ssd_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

    // R4: the output only follows what the first stage held a cycle earlier
    a_r4_two_stage: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sync_q == $past(meta_q)));
endmodule

// File: rtl/ssd_chan_fsm.sv
module ssd_chan_fsm
    import ssd_pkg::*;
#(
    parameter int START_CYCLES = 64,
    localparam int CW = $clog2(START_CYCLES + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      active_i,
    input  logic      below_s_i,
    output chan_out_t out_o,
    output logic      clamped_o
);
    chan_st_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            ST_RUN: begin
                if (!active_i) st_d = ST_DISCH;
            end
            ST_DISCH: begin
                if (active_i)       st_d = ST_RUN;
                else if (below_s_i) st_d = ST_CLAMP;
            end
            ST_CLAMP: begin
                if (active_i) begin
                    st_d  = ST_START;
                    cnt_d = '0;
                end
            end
            ST_START: begin
                if (!active_i)
                    st_d = ST_DISCH;
                else if (cnt_q == CW'(START_CYCLES - 1))
                    st_d = ST_RUN;
                else
                    cnt_d = cnt_q + 1'b1;
            end
            default: st_d = ST_DISCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_DISCH;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign out_o     = decode_state(st_q);
    assign clamped_o = (st_q == ST_CLAMP);

    a_r2_run_exit: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && !active_i) |=> (out_o.dsch && !out_o.pwm));
    a_r3_disch_gate_off: assert property (@(posedge clk) disable iff (rst)
        out_o.dsch |-> (out_o.ls == LS_OFF && !out_o.pwm));
    a_r4_hold_without_flag: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DISCH && !active_i && !below_s_i) |=> (st_q == ST_DISCH));
    a_r5_clamp_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CLAMP && !active_i) |=> (out_o.ls == LS_ON));
    a_r6_abort: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DISCH && active_i) |=> (out_o.pwm && !out_o.ss && !out_o.dsch));
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_START) |-> (cnt_q < CW'(START_CYCLES)));
    a_r8_ss_abort: assert property (@(posedge clk) disable iff (rst)
        (out_o.ss && !active_i) |=> out_o.dsch);
endmodule

// File: rtl/ssd_ref_ctl.sv
module ssd_ref_ctl #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] clamped_i,
    output logic           ref_en_o
);
    assign ref_en_o = ~(&clamped_i);

    // R9: reference may drop only when every channel is clamped
    a_r9_ref_hold: assert property (@(posedge clk) disable iff (rst)
        !ref_en_o |-> ($countones(clamped_i) == NCH));
endmodule

// File: rtl/ssd_sequencer.sv
module ssd_sequencer
    import ssd_pkg::*;
#(
    parameter int NCH          = 2,
    parameter int START_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   en_pin,
    input  logic [NCH-1:0]   uv_latch,
    input  logic             uvlo,
    input  logic [NCH-1:0]   below_raw,
    output logic [NCH-1:0]   dsch_sw_en,
    output logic [NCH-1:0]   pwm_en,
    output logic [NCH-1:0]   ss_active,
    output logic [2*NCH-1:0] ls_cmd,
    output logic             ref_en
);
    logic [NCH-1:0] below_s;
    logic [NCH-1:0] active;
    logic [NCH-1:0] clamped;

    assign active = en_pin & ~uv_latch & {NCH{~uvlo}};

    ssd_sync2 #(.W(NCH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (below_raw),
        .q_o (below_s)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_out_t co;
        ssd_chan_fsm #(.START_CYCLES(START_CYCLES)) u_fsm (
            .clk       (clk),
            .rst       (rst),
            .active_i  (active[i]),
            .below_s_i (below_s[i]),
            .out_o     (co),
            .clamped_o (clamped[i])
        );
        assign dsch_sw_en[i]     = co.dsch;
        assign pwm_en[i]         = co.pwm;
        assign ss_active[i]      = co.ss;
        assign ls_cmd[2*i +: 2]  = co.ls;

        // R5: a held-on low side never coexists with PWM or the discharge switch
        a_r5_clamp_excl: assert property (@(posedge clk) disable iff (rst)
            (ls_cmd[2*i +: 2] == 2'b10) |-> (!pwm_en[i] && !dsch_sw_en[i]));
    end

    ssd_ref_ctl #(.NCH(NCH)) u_ref (
        .clk       (clk),
        .rst       (rst),
        .clamped_i (clamped),
        .ref_en_o  (ref_en)
    );
endmodule

// File: tb/ssd_sequencer_tb_top.sv
module ssd_sequencer_tb_top;
    localparam int NCH = 2;
    localparam int SC  = 4;

    logic clk = 1'b0;
    logic rst;
    logic [NCH-1:0] en_pin, uv_latch, below_raw;
    logic uvlo;
    logic [NCH-1:0] dsch_sw_en, pwm_en, ss_active;
    logic [2*NCH-1:0] ls_cmd;
    logic ref_en;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    ssd_sequencer #(.NCH(NCH), .START_CYCLES(SC)) dut_i (
        .clk(clk), .rst(rst), .en_pin(en_pin), .uv_latch(uv_latch),
        .uvlo(uvlo), .below_raw(below_raw), .dsch_sw_en(dsch_sw_en),
        .pwm_en(pwm_en), .ss_active(ss_active), .ls_cmd(ls_cmd), .ref_en(ref_en)
    );

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // {dsch, pwm, ss, ls[1:0]} for channel ch
    function automatic logic [7:0] ch_word(int ch);
        return {3'b0, dsch_sw_en[ch], pwm_en[ch], ss_active[ch], ls_cmd[2*ch +: 2]};
    endfunction

    localparam logic [7:0] W_RUN   = 8'b000_0_1_0_00;
    localparam logic [7:0] W_DISCH = 8'b000_1_0_0_01;
    localparam logic [7:0] W_CLAMP = 8'b000_0_0_0_10;
    localparam logic [7:0] W_START = 8'b000_0_1_1_00;

    task automatic step(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; en_pin = '0; uv_latch = '0; uvlo = 1'b0; below_raw = '0;
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 ch0", ch_word(0), W_DISCH);
        check("R1 ch1", ch_word(1), W_DISCH);
        check("R1 ref", {7'b0, ref_en}, 8'd1);
    endtask

    task automatic t_clamp_both();
        below_raw = 2'b11;
        step(2);
        check("R4 still discharging", ch_word(0), W_DISCH);
        check("R3 discharge outputs", ch_word(1), W_DISCH);
        step(1);
        check("R4/R5 ch0 clamped", ch_word(0), W_CLAMP);
        check("R5 ch1 clamped", ch_word(1), W_CLAMP);
        check("R9 ref off", {7'b0, ref_en}, 8'd0);
        below_raw = 2'b00;
        step(3);
        check("R5 clamp sticky", ch_word(0), W_CLAMP);
    endtask

    task automatic t_softstart();
        en_pin[0] = 1'b1;
        step(1);
        check("R7 start entered", ch_word(0), W_START);
        check("R9 ref back on", {7'b0, ref_en}, 8'd1);
        check("R10 ch1 unaffected", ch_word(1), W_CLAMP);
        step(SC - 1);
        check("R7 last start cycle", ch_word(0), W_START);
        step(1);
        check("R7 run after start", ch_word(0), W_RUN);
    endtask

    task automatic t_disable_causes();
        uv_latch[0] = 1'b1;
        step(1);
        check("R2 uv latch", ch_word(0), W_DISCH);
        uv_latch[0] = 1'b0;
        step(1);
        check("R6 abort to run", ch_word(0), W_RUN);
        uvlo = 1'b1;
        step(1);
        check("R2 uvlo", ch_word(0), W_DISCH);
        check("R10 ch1 still clamped", ch_word(1), W_CLAMP);
        uvlo = 1'b0;
        step(1);
        check("R6 abort after uvlo", ch_word(0), W_RUN);
        en_pin[0] = 1'b0;
        step(1);
        check("R2 enable low", ch_word(0), W_DISCH);
    endtask

    task automatic t_abort_priority();
        below_raw[0] = 1'b1;
        step(2);
        en_pin[0] = 1'b1;
        step(1);
        check("R6 active beats flag", ch_word(0), W_RUN);
        below_raw[0] = 1'b0;
        step(3);
    endtask

    task automatic t_ss_abort();
        en_pin[0] = 1'b0;
        below_raw[0] = 1'b1;
        step(1);
        check("R3 discharge", ch_word(0), W_DISCH);
        step(2);
        check("R5 clamp again", ch_word(0), W_CLAMP);
        en_pin[0] = 1'b1;
        step(1);
        check("R7 restart", ch_word(0), W_START);
        en_pin[0] = 1'b0;
        step(1);
        check("R8 disable in start", ch_word(0), W_DISCH);
        step(1);
        check("R4 clamp with synced flag", ch_word(0), W_CLAMP);
        check("R9 all clamped ref off", {7'b0, ref_en}, 8'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_clamp_both();
                t_softstart();
                t_disable_causes();
                t_abort_priority();
                t_ss_abort();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule